// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Unit

This unit lets two processors, one on each side of a dual-ported device, signal each other through small banks of 16-bit mailbox registers. Each side owns four mailboxes. It can write them and read them back. The opposite side can read them but cannot write them. When a side writes the upper byte of one of its own mailboxes, it raises a pending interrupt at the opposite side. The interrupted side clears that interrupt by reading the upper byte of the same mailbox. That read leaves the mailbox contents as they were.

Every side has three registers of its own. A mask register turns off individual interrupt sources. A cause register records only the sources that were unmasked at the moment they fired. A status register shows every pending source, whether masked or not. A side reaches its register space while its mailbox select is low and its memory chip enable is high. Driving both low at once is a forbidden combination, and the unit ignores it. All accesses are synchronous, and read data arrives one clock after the request.

Top module: `mbx_irq_unit`

## Requirements
- R1: After synchronous reset, all of the following are zero: the mailboxes, the mask, cause and status registers, and both read data outputs. Both interrupt outputs are high.
- R2: A side's access takes effect only while its mailbox select is low and its memory chip enable is high. With both low (forbidden), or with the select high, a write changes nothing, a read clears nothing, and the read data in the next cycle is zero.
- R3: Six-bit address map, seen from each side: addresses 0 to 3 hold the side's own mailbox 0 to 3 (read/write). Addresses 4 to 7 hold the opposite side's mailbox 0 to 3 (read-only). Address 8 is the mask, where bit i masks source i; it is read/write and is written only when the lower byte enable is high. Address 9 is the cause register and address 10 is the status register, both read-only. Every other address reads as zero.
- R4: A mailbox write updates bits 15:8 when the upper byte enable is high and bits 7:0 when the lower byte enable is high. A lane that is not enabled keeps its old value.
- R5: Read data is registered and appears in the cycle after the request. A lane whose byte enable is low reads as zero. A cycle with no valid read gives zero in the next cycle.
- R6: A write that enables the upper byte of the writer's own mailbox i sets status bit i at the opposite side. A write that enables only the lower byte sets nothing.
- R7: A read that enables the upper byte at the address of the opposite side's mailbox i (address 4+i) clears the reader's status bit i and cause bit i. The mailbox data stays unchanged.
- R8: When a set and a clear of the same status bit fall in the same cycle, the bit ends up set.
- R9: Cause bit i is set only when source i fires while mask bit i is zero. A later change of the mask does not alter the cause register.
- R10: A side's interrupt output, which is active low, is low exactly while some status bit at that side has its mask bit clear. The status register shows pending sources whatever the mask holds.
- R11: Writes to the opposite side's mailboxes (addresses 4 to 7), to cause, to status and to unmapped addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| a_mbx_sel_n | input | 1 | Side A mailbox select, active low |
| a_mem_ce_n | input | 1 | Side A memory chip enable, active low |
| a_wr | input | 1 | Side A write (1) or read (0) |
| a_be_hi | input | 1 | Side A upper byte enable |
| a_be_lo | input | 1 | Side A lower byte enable |
| a_addr | input | 6 | Side A register address |
| a_wdata | input | 16 | Side A write data |
| a_rdata | output | 16 | Side A read data, one cycle after the request |
| a_irq_n | output | 1 | Side A interrupt, active low |
| b_mbx_sel_n | input | 1 | Side B mailbox select, active low |
| b_mem_ce_n | input | 1 | Side B memory chip enable, active low |
| b_wr | input | 1 | Side B write (1) or read (0) |
| b_be_hi | input | 1 | Side B upper byte enable |
| b_be_lo | input | 1 | Side B lower byte enable |
| b_addr | input | 6 | Side B register address |
| b_wdata | input | 16 | Side B write data |
| b_rdata | output | 16 | Side B read data, one cycle after the request |
| b_irq_n | output | 1 | Side B interrupt, active low |

## Verification
Read data is due one clock edge after the request cycle. The driver queues the expected word for both sides in every cycle. The monitor pops and compares those words shortly after the next rising edge. Mailbox writes, status sets and clears, and mask writes all take effect at the edge that samples the request. The interrupt outputs are decoded from those registers without a further stage, so every interrupt check sits at the falling edge right after that edge. A read in the same cycle as a write to the same register therefore expects the old contents.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;

    localparam int unsigned SIDES = 2;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_OWN,
        ACC_PEER,
        ACC_MASK,
        ACC_CAUSE,
        ACC_STAT
    } acc_kind_e;

    typedef struct packed {
        logic valid;
        logic wr;
        logic hi;
        logic lo;
    } acc_ctl_t;

    // mailbox space is open only with select low and memory enable high
    function automatic logic access_open(logic sel_n, logic ce_n);
        return !sel_n && ce_n;
    endfunction

endpackage

// File: rtl/mbx_decode.sv
`timescale 1ns/1ps
module mbx_decode
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_BOX = 4,
    parameter int unsigned ADDR_W  = 6,
    parameter int unsigned IDX_W   = 2
) (
    input  logic              sel_n,
    input  logic              ce_n,
    input  logic              wr,
    input  logic              be_hi,
    input  logic              be_lo,
    input  logic [ADDR_W-1:0] addr,
    output acc_kind_e         kind,
    output logic [IDX_W-1:0]  idx,
    output acc_ctl_t          ctl
);

    localparam logic [ADDR_W-1:0] OWN_END  = ADDR_W'(NUM_BOX);
    localparam logic [ADDR_W-1:0] PEER_END = ADDR_W'(2 * NUM_BOX);
    localparam logic [ADDR_W-1:0] MASK_AD  = PEER_END;
    localparam logic [ADDR_W-1:0] CAUSE_AD = PEER_END + ADDR_W'(1);
    localparam logic [ADDR_W-1:0] STAT_AD  = PEER_END + ADDR_W'(2);

    always_comb begin
        ctl.valid = access_open(sel_n, ce_n);
        ctl.wr    = wr;
        ctl.hi    = be_hi;
        ctl.lo    = be_lo;
        kind      = ACC_NONE;
        idx       = '0;
        if (ctl.valid) begin
            if (addr < OWN_END) begin
                kind = ACC_OWN;
                idx  = IDX_W'(addr);
            end else if (addr < PEER_END) begin
                kind = ACC_PEER;
                idx  = IDX_W'(addr - OWN_END);
            end else if (addr == MASK_AD) begin
                kind = ACC_MASK;
            end else if (addr == CAUSE_AD) begin
                kind = ACC_CAUSE;
            end else if (addr == STAT_AD) begin
                kind = ACC_STAT;
            end
        end
    end

endmodule

// File: rtl/mbx_bank.sv
`timescale 1ns/1ps
module mbx_bank #(
    parameter int unsigned NUM_BOX = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned IDX_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            we,
    input  logic [IDX_W-1:0]                idx,
    input  logic                            be_hi,
    input  logic                            be_lo,
    input  logic [DATA_W-1:0]               wdata,
    output logic [NUM_BOX-1:0][DATA_W-1:0]  words
);

    localparam int unsigned HALF = DATA_W / 2;

    for (genvar g = 0; g < NUM_BOX; g++) begin : g_box
        always_ff @(posedge clk) begin
            if (rst) begin
                words[g] <= '0;
            end else if (we && (idx == IDX_W'(g))) begin
                if (be_hi) words[g][DATA_W-1:HALF] <= wdata[DATA_W-1:HALF];
                if (be_lo) words[g][HALF-1:0]      <= wdata[HALF-1:0];
            end
        end
    end

endmodule

// File: rtl/mbx_irq_ctrl.sv
`timescale 1ns/1ps
module mbx_irq_ctrl #(
    parameter int unsigned NUM_BOX = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_BOX-1:0] set_v,
    input  logic [NUM_BOX-1:0] clr_v,
    input  logic               mask_we,
    input  logic [NUM_BOX-1:0] mask_wd,
    output logic [NUM_BOX-1:0] mask,
    output logic [NUM_BOX-1:0] cause,
    output logic [NUM_BOX-1:0] status,
    output logic               irq_n
);

    // a set in the same cycle as a clear keeps the bit
    always_ff @(posedge clk) begin
        if (rst) begin
            mask   <= '0;
            cause  <= '0;
            status <= '0;
        end else begin
            status <= set_v | (status & ~clr_v);
            cause  <= (set_v & ~mask) | (cause & ~clr_v);
            if (mask_we) mask <= mask_wd;
        end
    end

    assign irq_n = ~|(status & ~mask);

endmodule

// File: rtl/mbx_irq_unit.sv
`timescale 1ns/1ps
module mbx_irq_unit
    import mbx_pkg::*;
#(
    parameter int unsigned NUM_BOX = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              a_mbx_sel_n,
    input  logic              a_mem_ce_n,
    input  logic              a_wr,
    input  logic              a_be_hi,
    input  logic              a_be_lo,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_wdata,
    output logic [DATA_W-1:0] a_rdata,
    output logic              a_irq_n,
    input  logic              b_mbx_sel_n,
    input  logic              b_mem_ce_n,
    input  logic              b_wr,
    input  logic              b_be_hi,
    input  logic              b_be_lo,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_wdata,
    output logic [DATA_W-1:0] b_rdata,
    output logic              b_irq_n
);

    localparam int unsigned IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;
    localparam int unsigned HALF  = DATA_W / 2;

    logic                           sel_n_v [SIDES];
    logic                           ce_n_v  [SIDES];
    logic                           wr_v    [SIDES];
    logic                           hi_v    [SIDES];
    logic                           lo_v    [SIDES];
    logic [ADDR_W-1:0]              addr_v  [SIDES];
    logic [DATA_W-1:0]              wdata_v [SIDES];
    logic [DATA_W-1:0]              rdata_v [SIDES];
    logic                           irq_n_v [SIDES];
    logic [NUM_BOX-1:0][DATA_W-1:0] words_v [SIDES];
    logic [NUM_BOX-1:0]             hiwr_oh [SIDES];
    logic [NUM_BOX-1:0]             stat_v  [SIDES];
    logic [NUM_BOX-1:0]             mask_v  [SIDES];
    logic [NUM_BOX-1:0]             cause_v [SIDES];

    logic [2*NUM_BOX-1:0]           status_all;
    logic [2*NUM_BOX-1:0]           mask_all;
    logic [2*NUM_BOX-1:0]           cause_all;

    assign sel_n_v[0] = a_mbx_sel_n;  assign sel_n_v[1] = b_mbx_sel_n;
    assign ce_n_v[0]  = a_mem_ce_n;   assign ce_n_v[1]  = b_mem_ce_n;
    assign wr_v[0]    = a_wr;         assign wr_v[1]    = b_wr;
    assign hi_v[0]    = a_be_hi;      assign hi_v[1]    = b_be_hi;
    assign lo_v[0]    = a_be_lo;      assign lo_v[1]    = b_be_lo;
    assign addr_v[0]  = a_addr;       assign addr_v[1]  = b_addr;
    assign wdata_v[0] = a_wdata;      assign wdata_v[1] = b_wdata;
    assign a_rdata    = rdata_v[0];   assign b_rdata    = rdata_v[1];
    assign a_irq_n    = irq_n_v[0];   assign b_irq_n    = irq_n_v[1];

    assign status_all = {stat_v[1], stat_v[0]};
    assign mask_all   = {mask_v[1], mask_v[0]};
    assign cause_all  = {cause_v[1], cause_v[0]};

    for (genvar s = 0; s < SIDES; s++) begin : g_side
        localparam int P = 1 - s;

        acc_kind_e          kind;
        logic [IDX_W-1:0]   idx;
        acc_ctl_t           ctl;
        logic [NUM_BOX-1:0] idx_oh;
        logic [NUM_BOX-1:0] clr_oh;
        logic [DATA_W-1:0]  sel_word;
        logic [DATA_W-1:0]  rd_d;
        logic [DATA_W-1:0]  rd_q;

        mbx_decode #(
            .NUM_BOX (NUM_BOX),
            .ADDR_W  (ADDR_W),
            .IDX_W   (IDX_W)
        ) u_dec (
            .sel_n (sel_n_v[s]),
            .ce_n  (ce_n_v[s]),
            .wr    (wr_v[s]),
            .be_hi (hi_v[s]),
            .be_lo (lo_v[s]),
            .addr  (addr_v[s]),
            .kind  (kind),
            .idx   (idx),
            .ctl   (ctl)
        );

        assign idx_oh = NUM_BOX'(1) << idx;
        assign hiwr_oh[s] = (kind == ACC_OWN && ctl.wr && ctl.hi) ? idx_oh : '0;
        assign clr_oh     = (kind == ACC_PEER && !ctl.wr && ctl.hi) ? idx_oh : '0;

        mbx_bank #(
            .NUM_BOX (NUM_BOX),
            .DATA_W  (DATA_W),
            .IDX_W   (IDX_W)
        ) u_bank (
            .clk   (clk),
            .rst   (rst),
            .we    (kind == ACC_OWN && ctl.wr),
            .idx   (idx),
            .be_hi (ctl.hi),
            .be_lo (ctl.lo),
            .wdata (wdata_v[s]),
            .words (words_v[s])
        );

        mbx_irq_ctrl #(
            .NUM_BOX (NUM_BOX)
        ) u_irq (
            .clk     (clk),
            .rst     (rst),
            .set_v   (hiwr_oh[P]),
            .clr_v   (clr_oh),
            .mask_we (kind == ACC_MASK && ctl.wr && ctl.lo),
            .mask_wd (wdata_v[s][NUM_BOX-1:0]),
            .mask    (mask_v[s]),
            .cause   (cause_v[s]),
            .status  (stat_v[s]),
            .irq_n   (irq_n_v[s])
        );

        always_comb begin
            unique case (kind)
                ACC_OWN:   sel_word = words_v[s][idx];
                ACC_PEER:  sel_word = words_v[P][idx];
                ACC_MASK:  sel_word = DATA_W'(mask_v[s]);
                ACC_CAUSE: sel_word = DATA_W'(cause_v[s]);
                ACC_STAT:  sel_word = DATA_W'(stat_v[s]);
                default:   sel_word = '0;
            endcase
            rd_d = '0;
            if (ctl.valid && !ctl.wr) begin
                if (ctl.hi) rd_d[DATA_W-1:HALF] = sel_word[DATA_W-1:HALF];
                if (ctl.lo) rd_d[HALF-1:0]      = sel_word[HALF-1:0];
            end
        end

        always_ff @(posedge clk) begin
            if (rst) rd_q <= '0;
            else     rd_q <= rd_d;
        end

        assign rdata_v[s] = rd_q;
    end

endmodule

// File: rtl/mbx_irq_unit_chk.sv
`timescale 1ns/1ps
module mbx_irq_unit_chk #(
    parameter int unsigned NUM_BOX = 4,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned ADDR_W  = 6
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 a_mbx_sel_n,
    input logic                 a_mem_ce_n,
    input logic                 a_wr,
    input logic                 a_be_hi,
    input logic                 a_be_lo,
    input logic [ADDR_W-1:0]    a_addr,
    input logic [DATA_W-1:0]    a_wdata,
    input logic [DATA_W-1:0]    a_rdata,
    input logic                 a_irq_n,
    input logic                 b_mbx_sel_n,
    input logic                 b_mem_ce_n,
    input logic                 b_wr,
    input logic                 b_be_hi,
    input logic [ADDR_W-1:0]    b_addr,
    input logic                 b_irq_n,
    input logic [2*NUM_BOX-1:0] status_all,
    input logic [2*NUM_BOX-1:0] mask_all,
    input logic [2*NUM_BOX-1:0] cause_all
);

    localparam int unsigned IDX_W = (NUM_BOX > 1) ? $clog2(NUM_BOX) : 1;
    localparam logic [ADDR_W-1:0] NB  = ADDR_W'(NUM_BOX);
    localparam logic [ADDR_W-1:0] NB2 = ADDR_W'(2 * NUM_BOX);

    logic               a_open, b_open;
    logic               a_up_wr, b_up_rd, a_mask_wr;
    logic [NUM_BOX-1:0] a_oh, b_oh;
    logic [NUM_BOX-1:0] st_a, st_b, mk_a;

    assign a_open    = !a_mbx_sel_n && a_mem_ce_n;
    assign b_open    = !b_mbx_sel_n && b_mem_ce_n;
    assign a_up_wr   = a_open && a_wr && a_be_hi && (a_addr < NB);
    assign b_up_rd   = b_open && !b_wr && b_be_hi && (b_addr >= NB) && (b_addr < NB2);
    assign a_mask_wr = a_open && a_wr && a_be_lo && (a_addr == NB2);
    assign a_oh      = NUM_BOX'(1) << a_addr[IDX_W-1:0];
    assign b_oh      = NUM_BOX'(1) << IDX_W'(b_addr - NB);
    assign st_a      = status_all[NUM_BOX-1:0];
    assign st_b      = status_all[2*NUM_BOX-1:NUM_BOX];
    assign mk_a      = mask_all[NUM_BOX-1:0];

    // R2
    a_r2_forbidden_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (!a_mbx_sel_n && !a_mem_ce_n) |=> (a_rdata == '0));

    // R6
    a_r6_upper_write_sets_peer: assert property (@(posedge clk) disable iff (rst)
        a_up_wr |=> ((st_b & $past(a_oh)) == $past(a_oh)));

    // R7
    a_r7_upper_read_clears: assert property (@(posedge clk) disable iff (rst)
        (b_up_rd && !a_up_wr) |=> ((st_b & $past(b_oh)) == '0));

    // R9
    a_r9_cause_within_status: assert property (@(posedge clk) disable iff (rst)
        (cause_all & ~status_all) == '0);

    // R10
    a_r10_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        !a_irq_n |-> (|st_a));

    a_r10_irq_b_needs_pending: assert property (@(posedge clk) disable iff (rst)
        !b_irq_n |-> (|st_b));

    // R3
    a_r3_mask_write: assert property (@(posedge clk) disable iff (rst)
        a_mask_wr |=> (mk_a == $past(a_wdata[NUM_BOX-1:0])));

endmodule

bind mbx_irq_unit mbx_irq_unit_chk #(
    .NUM_BOX (NUM_BOX),
    .DATA_W  (DATA_W),
    .ADDR_W  (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .a_mbx_sel_n (a_mbx_sel_n),
    .a_mem_ce_n  (a_mem_ce_n),
    .a_wr        (a_wr),
    .a_be_hi     (a_be_hi),
    .a_be_lo     (a_be_lo),
    .a_addr      (a_addr),
    .a_wdata     (a_wdata),
    .a_rdata     (a_rdata),
    .a_irq_n     (a_irq_n),
    .b_mbx_sel_n (b_mbx_sel_n),
    .b_mem_ce_n  (b_mem_ce_n),
    .b_wr        (b_wr),
    .b_be_hi     (b_be_hi),
    .b_addr      (b_addr),
    .b_irq_n     (b_irq_n),
    .status_all  (status_all),
    .mask_all    (mask_all),
    .cause_all   (cause_all)
);

// File: tb/mbx_irq_unit_test.sv
`timescale 1ns/1ps
module mbx_irq_unit_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        sel_n [2];
    logic        ce_n  [2];
    logic        wr    [2];
    logic        hi    [2];
    logic        lo    [2];
    logic [5:0]  ad    [2];
    logic [15:0] wd    [2];
    logic [15:0] a_rdata, b_rdata;
    logic        a_irq_n, b_irq_n;

    logic [15:0] exp_v [2];
    string       tag_v [2];

    typedef struct {
        int          side;
        logic [15:0] v;
        string       tag;
    } item_t;

    item_t sbq[$];
    int nvec  = 0;
    int nfail = 0;

    always #10 clk = ~clk;

    mbx_irq_unit uut (
        .clk(clk), .rst(rst),
        .a_mbx_sel_n(sel_n[0]), .a_mem_ce_n(ce_n[0]), .a_wr(wr[0]),
        .a_be_hi(hi[0]), .a_be_lo(lo[0]), .a_addr(ad[0]), .a_wdata(wd[0]),
        .a_rdata(a_rdata), .a_irq_n(a_irq_n),
        .b_mbx_sel_n(sel_n[1]), .b_mem_ce_n(ce_n[1]), .b_wr(wr[1]),
        .b_be_hi(hi[1]), .b_be_lo(lo[1]), .b_addr(ad[1]), .b_wdata(wd[1]),
        .b_rdata(b_rdata), .b_irq_n(b_irq_n)
    );

    task automatic idle();
        for (int s = 0; s < 2; s++) begin
            sel_n[s] = 1'b1; ce_n[s] = 1'b1; wr[s] = 1'b0;
            hi[s] = 1'b0; lo[s] = 1'b0; ad[s] = '0; wd[s] = '0;
            exp_v[s] = '0; tag_v[s] = "R5 idle gives zero";
        end
    endtask

    task automatic raw(int s, logic sn, logic cn, logic w, logic h, logic l,
                       logic [5:0] a, logic [15:0] d, string t);
        sel_n[s] = sn; ce_n[s] = cn; wr[s] = w; hi[s] = h; lo[s] = l;
        ad[s] = a; wd[s] = d; exp_v[s] = '0; tag_v[s] = t;
    endtask

    task automatic wt(int s, logic [5:0] a, logic [15:0] d, logic h, logic l, string t);
        raw(s, 1'b0, 1'b1, 1'b1, h, l, a, d, t);
    endtask

    task automatic rd(int s, logic [5:0] a, logic h, logic l, logic [15:0] e, string t);
        raw(s, 1'b0, 1'b1, 1'b0, h, l, a, 16'h0, t);
        exp_v[s] = {h ? e[15:8] : 8'h00, l ? e[7:0] : 8'h00};
    endtask

    // queue expectations for both sides, run one cycle, return to idle
    task automatic tick();
        sbq.push_back('{0, exp_v[0], tag_v[0]});
        sbq.push_back('{1, exp_v[1], tag_v[1]});
        @(negedge clk);
        idle();
    endtask

    task automatic chk(logic act, logic e, string t);
        nvec++;
        if (act !== e) begin
            nfail++;
            $display("FAIL %s: actual %0b expected %0b", t, act, e);
        end
    endtask

    // monitor: results are due just after the edge that follows the request
    always @(posedge clk) begin
        #2;
        while (sbq.size() > 0) begin
            item_t it;
            logic [15:0] act;
            it  = sbq.pop_front();
            act = (it.side == 0) ? a_rdata : b_rdata;
            nvec++;
            if (act !== it.v) begin
                nfail++;
                $display("FAIL %s (side %0d): actual %h expected %h", it.tag, it.side, act, it.v);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

    initial begin
        idle();
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(a_irq_n, 1'b1, "R1 a_irq_n after reset");
        chk(b_irq_n, 1'b1, "R1 b_irq_n after reset");
        rd(0, 6'd0, 1, 1, 16'h0000, "R1 mailbox zero");
        rd(1, 6'd10, 1, 1, 16'h0000, "R1 status zero");
        tick();
        rd(0, 6'd8, 1, 1, 16'h0000, "R1 mask zero");
        rd(1, 6'd9, 1, 1, 16'h0000, "R1 cause zero");
        tick();

        // R6: upper byte write from A raises B
        wt(0, 6'd1, 16'hA55A, 1, 1, "R6 write");
        tick();
        chk(b_irq_n, 1'b0, "R6 b_irq_n asserted");
        chk(a_irq_n, 1'b1, "R6 a_irq_n untouched");
        rd(1, 6'd10, 1, 1, 16'h0002, "R10 status bit1");
        rd(0, 6'd1, 1, 1, 16'hA55A, "R3 own readback");
        tick();
        rd(1, 6'd9, 1, 1, 16'h0002, "R9 cause bit1");
        tick();

        // R7: lower-only read leaves it, upper read clears
        rd(1, 6'd5, 0, 1, 16'hA55A, "R5 lower lane only");
        tick();
        chk(b_irq_n, 1'b0, "R7 lower read keeps irq");
        rd(1, 6'd5, 1, 0, 16'hA55A, "R5 upper lane only");
        tick();
        chk(b_irq_n, 1'b1, "R7 upper read clears irq");
        rd(1, 6'd10, 1, 1, 16'h0000, "R7 status cleared");
        rd(0, 6'd1, 1, 1, 16'hA55A, "R7 data unchanged");
        tick();
        rd(1, 6'd9, 1, 1, 16'h0000, "R7 cause cleared");
        tick();

        // R4 byte lanes, R6 lower-only write
        wt(0, 6'd2, 16'h1234, 0, 1, "R4 lower write");
        tick();
        chk(b_irq_n, 1'b1, "R6 lower-only write no irq");
        rd(0, 6'd2, 1, 1, 16'h0034, "R4 lower lane only");
        tick();
        wt(0, 6'd2, 16'hAB00, 1, 0, "R4 upper write");
        tick();
        chk(b_irq_n, 1'b0, "R6 upper write irq");
        rd(1, 6'd6, 1, 1, 16'hAB34, "R4 merged word");
        tick();
        chk(b_irq_n, 1'b1, "R7 cleared by full read");

        // R9/R10 masking
        wt(1, 6'd8, 16'h0001, 0, 1, "R3 mask write");
        tick();
        rd(1, 6'd8, 1, 1, 16'h0001, "R3 mask readback");
        wt(0, 6'd0, 16'h7700, 1, 0, "R9 masked source");
        tick();
        chk(b_irq_n, 1'b1, "R10 masked source no irq");
        rd(1, 6'd10, 1, 1, 16'h0001, "R10 status ignores mask");
        tick();
        rd(1, 6'd9, 1, 1, 16'h0000, "R9 masked cause not set");
        tick();
        wt(1, 6'd8, 16'h0000, 0, 1, "R10 unmask");
        tick();
        chk(b_irq_n, 1'b0, "R10 unmasked pending irq");
        rd(1, 6'd9, 1, 1, 16'h0000, "R9 cause unchanged by mask");
        tick();
        rd(1, 6'd4, 1, 0, 16'h7700, "R7 clear box0");
        tick();
        chk(b_irq_n, 1'b1, "R7 box0 cleared");

        // R8 set wins
        wt(0, 6'd3, 16'h0100, 1, 1, "R8 first set");
        tick();
        chk(b_irq_n, 1'b0, "R8 pending");
        wt(0, 6'd3, 16'h0200, 1, 1, "R8 second set");
        rd(1, 6'd7, 1, 0, 16'h0100, "R8 read old word");
        tick();
        chk(b_irq_n, 1'b0, "R8 set wins over clear");
        rd(1, 6'd10, 1, 1, 16'h0008, "R8 status kept");
        tick();
        rd(1, 6'd7, 1, 1, 16'h0200, "R8 clear later");
        tick();
        chk(b_irq_n, 1'b1, "R8 cleared after");

        // reverse direction
        wt(1, 6'd0, 16'hBEEF, 1, 1, "R6 B to A");
        tick();
        chk(a_irq_n, 1'b0, "R6 a_irq_n asserted");
        rd(0, 6'd4, 1, 1, 16'hBEEF, "R3 peer read");
        tick();
        chk(a_irq_n, 1'b1, "R7 a cleared");

        // R11 ignored writes
        wt(0, 6'd5, 16'hFFFF, 1, 1, "R11 peer write");
        tick();
        chk(a_irq_n, 1'b1, "R11 a no irq");
        chk(b_irq_n, 1'b1, "R11 b no irq");
        rd(0, 6'd5, 1, 1, 16'h0000, "R11 peer box intact");
        rd(1, 6'd1, 1, 1, 16'h0000, "R11 owner box intact");
        tick();
        wt(0, 6'd10, 16'hFFFF, 1, 1, "R11 status write");
        tick();
        rd(0, 6'd10, 1, 1, 16'h0000, "R11 status intact");
        tick();

        // R2 forbidden and deselected
        raw(0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 6'd0, 16'hDEAD, "R2 forbidden write");
        tick();
        chk(b_irq_n, 1'b1, "R2 forbidden no irq");
        rd(0, 6'd0, 1, 1, 16'h7700, "R2 box unchanged");
        tick();
        raw(0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 6'd0, 16'h0, "R2 forbidden read zero");
        tick();
        raw(0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 6'd0, 16'h1111, "R2 deselected write");
        tick();
        chk(b_irq_n, 1'b1, "R2 deselected no irq");
        rd(0, 6'd0, 1, 1, 16'h7700, "R2 box still unchanged");
        tick();

        // R3 unmapped, R5 no lanes
        rd(0, 6'd63, 1, 1, 16'h0000, "R3 unmapped 63");
        rd(1, 6'd11, 1, 1, 16'h0000, "R3 unmapped 11");
        tick();
        rd(0, 6'd0, 0, 0, 16'h7700, "R5 no lanes zero");
        tick();

        tick();
        repeat (2) @(negedge clk);
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule